// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides which operating mode a CAN-style controller is in: sleep, reset, halt or operation. Software writes a 16-bit control word holding a mode request, a sleep request, a bus-off recovery choice and a few configuration fields. A 16-bit status word reports whether the controller currently sits in reset. The one-hot mode outputs gate the protocol engine next to this block.

A mode change happens only at a safe point. A normal reset, a halt from operation and any entry into operation wait for the frame-boundary/bus-idle pulse from the protocol engine. A forced reset acts on the next cycle. A bus-off event can throw the controller into halt when the recovery field asks for it. Sleep can be entered only from reset or halt. Leaving sleep goes back to the mode the controller was in when it went to sleep. After hardware reset the controller is asleep, with reset as its return mode.

Top module: `can_mode_seq`

## Requirements
- R1: After hardware reset the controller is in sleep mode, the control word reads 0x0500 (sleep bit 10 set, mode field bits 9:8 = 01) and the status word reads 0x0000.
- R2: Clearing the sleep bit puts the controller, one cycle after the write, back in the mode it held when sleep was entered (reset after hardware reset).
- R3: Mode field 11 (forced reset) enters reset one cycle after the write, from operation or halt, without waiting for a frame boundary.
- R4: Mode field 01 (reset) written during operation keeps the controller in operation until a frame-boundary pulse, and reset is entered on the edge that samples the pulse. From halt, reset is entered one cycle after the write.
- R5: Mode field 00 (operation) takes effect from reset or halt only on the edge that samples a frame-boundary pulse.
- R6: Mode field 10 (halt) enters halt from reset one cycle after the write, and from operation only at a frame-boundary pulse. While halted the mode field reads 10.
- R7: A bus-off pulse during operation with recovery field bits 12:11 = 01 enters halt on the next edge and sets the mode field to 10. With recovery field 00 the pulse has no effect.
- R8: Writing 1 to the sleep bit during operation is discarded: the bit reads 0 and the mode stays operation. The same write in reset or halt enters sleep one cycle after the write.
- R9: Bits 0 (FIFO mailbox), 2:1 (ID format) and 12:11 (bus-off recovery) change only on writes made while in reset. Bit 3 (overrun select) is writable in any mode. Bits 7:4 and 15:13 always read 0.
- R10: Status bit 8 is 1 exactly while the controller is in reset. All other status bits read 0.
- R11: While sleep is set, writes that keep the sleep bit at 1 leave the mode field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| frame_bnd | input | 1 | Frame boundary / bus idle pulse from the protocol engine |
| bus_off | input | 1 | Bus-off entry event |
| ctl_rdata | output | 16 | Control word read-back |
| sts_rdata | output | 16 | Status word (bit 8: in reset) |
| mode_sleep | output | 1 | Controller is in sleep |
| mode_reset | output | 1 | Controller is in reset |
| mode_halt | output | 1 | Controller is in halt |
| mode_oper | output | 1 | Controller is in operation |

## Verification
The bench checks the cycles around a reset or halt request made during operation. A design that switched at once would cut a frame in half, and the bench would see reset or halt before the boundary pulse. It also checks that a forced reset needs no pulse at all. A design that waited for one would hang the software poll on the status bit.

Bus-off is driven with both recovery settings. This catches a halt that ignores the recovery field, and a halt whose mode field does not read back 10. Sleep is requested from operation and from halt, and mode writes are made while asleep. Waking then must return to halt, not to the pending request. A design that took the sleep request from operation, or followed a mode write made during sleep, would show the wrong mode lines after wake-up.

// File: rtl/cms_pkg.sv
package cms_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP = 2'd0,
        MODE_RESET = 2'd1,
        MODE_HALT  = 2'd2,
        MODE_OPER  = 2'd3
    } opmode_e;

    // mode request codes (control bits 9:8)
    localparam logic [1:0] REQ_OPER  = 2'b00;
    localparam logic [1:0] REQ_RESET = 2'b01;
    localparam logic [1:0] REQ_HALT  = 2'b10;
    localparam logic [1:0] REQ_FORCE = 2'b11;

    // bus-off recovery code that selects automatic halt
    localparam logic [1:0] BOR_AUTO_HALT = 2'b01;

    // control word bit positions
    localparam int CTL_FIFO_BIT = 0;
    localparam int CTL_IDF_LSB  = 1;
    localparam int CTL_OVR_BIT  = 3;
    localparam int CTL_REQ_LSB  = 8;
    localparam int CTL_SLP_BIT  = 10;
    localparam int CTL_BOR_LSB  = 11;
    localparam int CTL_TOP_BIT  = 12;

    // status word bit positions
    localparam int STS_RST_BIT  = 8;

    typedef struct packed {
        logic [1:0] bor;
        logic       sleep;
        logic [1:0] req;
        logic       ovr;
        logic [1:0] idf;
        logic       fifo;
    } ctl_fields_t;

    localparam ctl_fields_t CTL_RESET_VAL = '{
        bor: 2'b00, sleep: 1'b1, req: REQ_RESET, ovr: 1'b0, idf: 2'b00, fifo: 1'b0
    };

endpackage

// File: rtl/cms_ctrl_reg.sv
module cms_ctrl_reg
    import cms_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  opmode_e          cur_mode,
    input  logic             bo_halt,
    output ctl_fields_t      fld_q,
    output logic             sleep_nxt,
    output logic [REG_W-1:0] rdata
);

    ctl_fields_t fld_d;
    logic        in_reset;
    logic        sleep_ok;
    logic        unused_wbits;

    assign unused_wbits = ^{wdata[REG_W-1:CTL_TOP_BIT+1], wdata[CTL_REQ_LSB-1:CTL_OVR_BIT+1]};

    always_comb begin
        fld_d    = fld_q;
        in_reset = (cur_mode == MODE_RESET);
        sleep_ok = (cur_mode == MODE_RESET) || (cur_mode == MODE_HALT);
        if (wr_en) begin
            fld_d.ovr = wdata[CTL_OVR_BIT];
            if (in_reset) begin
                fld_d.fifo = wdata[CTL_FIFO_BIT];
                fld_d.idf  = wdata[CTL_IDF_LSB +: 2];
                fld_d.bor  = wdata[CTL_BOR_LSB +: 2];
            end
            if (fld_q.sleep) begin
                fld_d.sleep = wdata[CTL_SLP_BIT];
            end else begin
                fld_d.sleep = wdata[CTL_SLP_BIT] & sleep_ok;
            end
            if (!fld_d.sleep) begin
                fld_d.req = wdata[CTL_REQ_LSB +: 2];
            end
        end
        if (bo_halt) begin
            fld_d.req = REQ_HALT;
        end
        sleep_nxt = fld_d.sleep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= CTL_RESET_VAL;
        end else begin
            fld_q <= fld_d;
        end
    end

    always_comb begin
        rdata                      = '0;
        rdata[CTL_FIFO_BIT]        = fld_q.fifo;
        rdata[CTL_IDF_LSB +: 2]    = fld_q.idf;
        rdata[CTL_OVR_BIT]         = fld_q.ovr;
        rdata[CTL_REQ_LSB +: 2]    = fld_q.req;
        rdata[CTL_SLP_BIT]         = fld_q.sleep;
        rdata[CTL_BOR_LSB +: 2]    = fld_q.bor;
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != MODE_RESET) |=> ($stable(fld_q.fifo) && $stable(fld_q.idf) && $stable(fld_q.bor))); // R9

    AST_SLEEP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fld_q.sleep && cur_mode == MODE_OPER) |=> !fld_q.sleep); // R8

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_q.sleep && wr_en && wdata[CTL_SLP_BIT]) |=> $stable(fld_q.req)); // R11

endmodule

// File: rtl/cms_mode_fsm.sv
module cms_mode_fsm
    import cms_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ctl_fields_t fld,
    input  logic        sleep_nxt,
    input  logic        frame_bnd,
    input  logic        bus_off,
    output opmode_e     cur_mode,
    output logic        bo_halt
);

    typedef struct packed {
        opmode_e cur;
        opmode_e ret;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    unused_cfg;

    assign unused_cfg = ^{fld.fifo, fld.idf, fld.ovr};
    assign cur_mode   = st_q.cur;

    always_comb begin
        st_d    = st_q;
        bo_halt = bus_off && (st_q.cur == MODE_OPER) &&
                  (fld.bor == BOR_AUTO_HALT) && (fld.req != REQ_FORCE);
        if (fld.sleep) begin
            if (st_q.cur == MODE_RESET || st_q.cur == MODE_HALT) begin
                st_d.cur = MODE_SLEEP;
                st_d.ret = st_q.cur;
            end
        end else if (st_q.cur == MODE_SLEEP) begin
            st_d.cur = st_q.ret;
        end else if (sleep_nxt) begin
            st_d = st_q;
        end else if (bo_halt) begin
            st_d.cur = MODE_HALT;
        end else begin
            unique case (fld.req)
                REQ_FORCE: st_d.cur = MODE_RESET;
                REQ_RESET: begin
                    if (st_q.cur != MODE_OPER || frame_bnd) st_d.cur = MODE_RESET;
                end
                REQ_HALT: begin
                    if (st_q.cur != MODE_OPER || frame_bnd) st_d.cur = MODE_HALT;
                end
                default: begin
                    if (frame_bnd) st_d.cur = MODE_OPER;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cur <= MODE_SLEEP;
            st_q.ret <= MODE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    AST_FORCE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!fld.sleep && !sleep_nxt && fld.req == REQ_FORCE &&
         (st_q.cur == MODE_OPER || st_q.cur == MODE_HALT)) |=> (st_q.cur == MODE_RESET)); // R3

    AST_RESET_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cur == MODE_OPER && fld.req == REQ_RESET && !frame_bnd && !bus_off)
        |=> (st_q.cur == MODE_OPER)); // R4

    AST_OPER_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cur != MODE_OPER && !frame_bnd) |=> (st_q.cur != MODE_OPER)); // R5

    AST_BUSOFF_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && st_q.cur == MODE_OPER && fld.bor == BOR_AUTO_HALT && fld.req != REQ_FORCE)
        |=> (st_q.cur == MODE_HALT)); // R7

    AST_NO_SLEEP_FROM_OPER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cur == MODE_OPER) |=> (st_q.cur != MODE_SLEEP)); // R8

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import cms_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             frame_bnd,
    input  logic             bus_off,
    output logic [REG_W-1:0] ctl_rdata,
    output logic [REG_W-1:0] sts_rdata,
    output logic             mode_sleep,
    output logic             mode_reset,
    output logic             mode_halt,
    output logic             mode_oper
);

    ctl_fields_t fld;
    opmode_e     cur_mode;
    logic        sleep_nxt;
    logic        bo_halt;

    cms_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr),
        .wdata    (ctl_wdata),
        .cur_mode (cur_mode),
        .bo_halt  (bo_halt),
        .fld_q    (fld),
        .sleep_nxt(sleep_nxt),
        .rdata    (ctl_rdata)
    );

    cms_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fld      (fld),
        .sleep_nxt(sleep_nxt),
        .frame_bnd(frame_bnd),
        .bus_off  (bus_off),
        .cur_mode (cur_mode),
        .bo_halt  (bo_halt)
    );

    always_comb begin
        sts_rdata              = '0;
        sts_rdata[STS_RST_BIT] = (cur_mode == MODE_RESET);
        mode_sleep             = (cur_mode == MODE_SLEEP);
        mode_reset             = (cur_mode == MODE_RESET);
        mode_halt              = (cur_mode == MODE_HALT);
        mode_oper              = (cur_mode == MODE_OPER);
    end

    AST_HALT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_oper && bus_off && fld.bor == BOR_AUTO_HALT && fld.req != REQ_FORCE)
        |=> (ctl_rdata[CTL_REQ_LSB +: 2] == REQ_HALT)); // R6

endmodule

// File: tb/can_mode_seq_tb.sv
`timescale 1ns/1ps
module can_mode_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        frame_bnd = 1'b0;
    logic        bus_off = 1'b0;
    logic [15:0] ctl_rdata, sts_rdata;
    logic        mode_sleep, mode_reset, mode_halt, mode_oper;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [15:0] M_SLP = 16'h8, M_RST = 16'h4, M_HLT = 16'h2, M_OPR = 16'h1;

    always #2 clk = ~clk;

    can_mode_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .frame_bnd(frame_bnd), .bus_off(bus_off), .ctl_rdata(ctl_rdata),
        .sts_rdata(sts_rdata), .mode_sleep(mode_sleep), .mode_reset(mode_reset),
        .mode_halt(mode_halt), .mode_oper(mode_oper)
    );

    function automatic logic [15:0] mvec();
        return {12'b0, mode_sleep, mode_reset, mode_halt, mode_oper};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        tick();
        ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic bnd();
        frame_bnd = 1'b1; tick(); frame_bnd = 1'b0;
    endtask

    task automatic boff();
        bus_off = 1'b1; tick(); bus_off = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1 mode", mvec(), M_SLP);
        chk("R1 ctl", ctl_rdata, 16'h0500);
        chk("R1 sts", sts_rdata, 16'h0000);
    endtask

    task automatic t_wake();
        wr(16'h0100); tick();
        chk("R2 wake to reset", mvec(), M_RST);
        chk("R10 sts in reset", sts_rdata, 16'h0100);
    endtask

    task automatic t_config();
        wr(16'hE9FD);
        chk("R9 cfg in reset, reserved zero", ctl_rdata, 16'h090D);
    endtask

    task automatic t_enter_oper();
        wr(16'h080D); tick(); tick();
        chk("R5 waits for boundary", mvec(), M_RST);
        bnd();
        chk("R5 oper at boundary", mvec(), M_OPR);
        chk("R10 sts out of reset", sts_rdata, 16'h0000);
    endtask

    task automatic t_cfg_lock();
        wr(16'h0000);
        chk("R9 locked outside reset, bit3 free", ctl_rdata, 16'h0805);
    endtask

    task automatic t_sleep_ignored();
        wr(16'h0405); tick();
        chk("R8 sleep bit dropped", ctl_rdata, 16'h0805);
        chk("R8 still oper", mvec(), M_OPR);
    endtask

    task automatic t_normal_reset();
        wr(16'h0905); tick(); tick();
        chk("R4 oper until boundary", mvec(), M_OPR);
        bnd();
        chk("R4 reset at boundary", mvec(), M_RST);
        chk("R10 sts set", sts_rdata, 16'h0100);
    endtask

    task automatic t_halt_from_reset();
        wr(16'h0A05); tick();
        chk("R6 halt from reset", mvec(), M_HLT);
        chk("R6 field reads 10", ctl_rdata, 16'h0A05);
        chk("R10 sts clear in halt", sts_rdata, 16'h0000);
    endtask

    task automatic t_oper_from_halt();
        wr(16'h0805); tick();
        chk("R5 halt holds w/o boundary", mvec(), M_HLT);
        bnd();
        chk("R5 oper from halt", mvec(), M_OPR);
    endtask

    task automatic t_halt_from_oper();
        wr(16'h0A05); tick();
        chk("R6 oper until boundary", mvec(), M_OPR);
        bnd();
        chk("R6 halt at boundary", mvec(), M_HLT);
    endtask

    task automatic t_forced();
        wr(16'h0B05); tick();
        chk("R3 forced from halt", mvec(), M_RST);
        wr(16'h0805); bnd();
        chk("R3 back to oper", mvec(), M_OPR);
        wr(16'h0B05); tick();
        chk("R3 forced from oper", mvec(), M_RST);
        wr(16'h0905); tick();
        wr(16'h0A05); tick();
        wr(16'h0905); tick();
        chk("R4 reset from halt next cycle", mvec(), M_RST);
    endtask

    task automatic t_busoff_halt();
        wr(16'h0805); bnd();
        chk("R7 pre oper", mvec(), M_OPR);
        boff();
        chk("R7 bus-off halt", mvec(), M_HLT);
        chk("R7 field reads halt", ctl_rdata, 16'h0A05);
    endtask

    task automatic t_busoff_ignored();
        wr(16'h0B05); tick();
        wr(16'h0305);
        chk("R9 bor cleared in reset", ctl_rdata, 16'h0305);
        wr(16'h0005); bnd();
        boff();
        chk("R7 bus-off no effect mode", mvec(), M_OPR);
        chk("R7 bus-off no effect ctl", ctl_rdata, 16'h0005);
    endtask

    task automatic t_sleep_cycle();
        wr(16'h0205); bnd();
        chk("R6 halt pre sleep", mvec(), M_HLT);
        wr(16'h0605); tick();
        chk("R8 sleep from halt", mvec(), M_SLP);
        chk("R8 sleep bit reads 1", ctl_rdata, 16'h0605);
        wr(16'h0405); tick();
        chk("R11 mode frozen in sleep", ctl_rdata, 16'h0605);
        chk("R11 still sleeping", mvec(), M_SLP);
        wr(16'h0005); tick();
        chk("R2 wake to halt", mvec(), M_HLT);
        chk("R2 ctl after wake", ctl_rdata, 16'h0005);
        bnd();
        chk("R5 oper after wake", mvec(), M_OPR);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_wake();
        t_config();
        t_enter_oper();
        t_cfg_lock();
        t_sleep_ignored();
        t_normal_reset();
        t_halt_from_reset();
        t_oper_from_halt();
        t_halt_from_oper();
        t_forced();
        t_busoff_halt();
        t_busoff_ignored();
        t_sleep_cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule